// File: doc/BRIEF.md
# Peripheral Clock Routing Register Bank

This block holds one routing entry per peripheral clock channel. Each entry names the clock generator that feeds the channel, carries an enable bit, and carries a lock bit. Software reaches every entry through one 16-bit control word. The channel-number field of that word picks the entry that a write updates, and it also picks the entry that the read port shows. The per-channel generator selects and enables are exported as flat vectors, ready for the clock multiplexers placed downstream.

The bank responds to two kinds of reset. A power reset returns every entry to its default. A user reset spares locked entries and has its own rules for two channels. The timekeeping channel (channel 4) survives a user reset unless it is both unlocked and disabled. The watchdog channel (channel 3) takes its defaults from two nonvolatile configuration bits. The register port is plain control with no handshake. A write is accepted in the cycle that `wr_en` is high, and the read word is combinational from the stored pointer and the entries.

Top module: `clk_route_bank`

## Requirements
- R1: When `wr_en` is high, the word on `wr_word` is decoded as follows: channel number in bits [5:0], generator in bits [11:8], enable in bit 14, lock in bit 15. Bits [7:6] and [13:12] are ignored. If the channel number is valid and the entry is unlocked, the entry takes the generator, enable and lock values at that clock edge.
- R2: During power reset, every entry gets generator 0, enable 0 and lock 0, except the watchdog channel 3. Channel 3 gets generator 2, enable equal to `nv_wdt_en` and lock equal to `nv_wdt_lock`. The read pointer returns to channel 0.
- R3: On a user reset, a channel other than 3 or 4 clears its generator and enable when it is unlocked, and keeps them when it is locked.
- R4: On a user reset, channel 4 clears its generator and enable only when it is both unlocked and disabled. In every other case it is unchanged.
- R5: On a user reset, channel 3 reloads generator 2 and enable = `nv_wdt_en` when it is unlocked, and is unchanged when it is locked.
- R6: A user reset never changes the lock bit of any channel.
- R7: A write aimed at a locked entry changes nothing in that entry. Only a power reset clears a lock bit.
- R8: Channel numbers 0x26 to 0x3F are reserved. A write to a reserved channel changes no entry. While a reserved channel is selected, the read word shows zero in bits [15:6].
- R9: `rd_word` shows the entry picked by the channel number of the most recent write, whether or not that write took effect. Its layout is the same as `wr_word`: bits [5:0] repeat the channel number and bits [7:6] and [13:12] read 0. It reflects the write from the next cycle on.
- R10: Power reset overrides user reset, and user reset overrides a write issued in the same cycle. The read pointer still follows a write that happens during a user reset.
- R11: `ch_gen_o[4k+3:4k]` and `ch_en_o[k]` always show the generator and enable of channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| power_rst | input | 1 | Synchronous power reset strobe, active high |
| user_rst | input | 1 | Synchronous user reset strobe, active high |
| nv_wdt_en | input | 1 | Nonvolatile watchdog enable default |
| nv_wdt_lock | input | 1 | Nonvolatile watchdog always-on (lock) default |
| wr_en | input | 1 | Write strobe for the control word |
| wr_word | input | 16 | Control word: channel, generator, enable, lock |
| rd_word | output | 16 | Entry selected by the last written channel |
| ch_gen_o | output | 152 | Generator select, 4 bits per channel |
| ch_en_o | output | 38 | Clock enable, 1 bit per channel |

## Verification
Writes are tried at the edges of the channel range (0x00, 0x25) and at reserved numbers (0x26, 0x3F). This separates a real range check from a check that only masks to six bits. Entries are written in mixed states: locked and unlocked, enabled and disabled, on ordinary channels, on channel 3 and on channel 4. A user reset then tells apart the three clearing rules, and rewrites of locked entries show that the lock holds. Resets and writes are also made to collide in one cycle, under both settings of the nonvolatile bits, to show the priority order and to show the watchdog defaults coming from the configuration pins rather than from constants.

// File: rtl/clkrt_pkg.sv
package clkrt_pkg;
  localparam int ID_W   = 6;
  localparam int GEN_W  = 4;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_RTC   = 2'd1,
    KIND_WDT   = 2'd2
  } kind_e;

  typedef struct packed {
    logic             lock;
    logic             en;
    logic [1:0]       rsv_hi;
    logic [GEN_W-1:0] gen;
    logic [1:0]       rsv_lo;
    logic [ID_W-1:0]  id;
  } ctl_word_t;
endpackage

// File: rtl/clkrt_entry.sv
module clkrt_entry
  import clkrt_pkg::*;
#(
  parameter kind_e            KIND    = KIND_PLAIN,
  parameter logic [GEN_W-1:0] PWR_GEN = '0
) (
  input  logic             clk,
  input  logic             pwr_rst,
  input  logic             usr_rst,
  input  logic             nv_en,
  input  logic             nv_lock,
  input  logic             wr_hit,
  input  logic [GEN_W-1:0] wr_gen,
  input  logic             wr_en_bit,
  input  logic             wr_lock,
  output logic [GEN_W-1:0] gen_o,
  output logic             en_o,
  output logic             lock_o
);
  localparam bit IS_WDT = (KIND == KIND_WDT);

  logic [GEN_W-1:0] gen_q;
  logic             en_q;
  logic             lock_q;

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      gen_q  <= IS_WDT ? PWR_GEN : '0;
      en_q   <= IS_WDT & nv_en;
      lock_q <= IS_WDT & nv_lock;
    end else if (usr_rst) begin
      if (!lock_q) begin
        case (KIND)
          KIND_WDT: begin
            gen_q <= PWR_GEN;
            en_q  <= nv_en;
          end
          KIND_RTC: begin
            if (!en_q) gen_q <= '0;
          end
          default: begin
            gen_q <= '0;
            en_q  <= 1'b0;
          end
        endcase
      end
    end else if (wr_hit && !lock_q) begin
      gen_q  <= wr_gen;
      en_q   <= wr_en_bit;
      lock_q <= wr_lock;
    end
  end

  assign gen_o  = gen_q;
  assign en_o   = en_q;
  assign lock_o = lock_q;

  logic armed;
  always_ff @(posedge clk) armed <= !pwr_rst;

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (pwr_rst)
    armed && lock_q |=> lock_q);

  assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (pwr_rst)
    armed && lock_q |=> $stable(gen_q) && $stable(en_q));

  if (KIND == KIND_WDT) begin : g_wdt_chk
    assert_wdt_reload_R5: assert property (@(posedge clk) disable iff (pwr_rst)
      armed && usr_rst && !lock_q |=> gen_q == PWR_GEN && en_q == $past(nv_en));
  end

  if (KIND == KIND_RTC) begin : g_rtc_chk
    assert_rtc_keep_R4: assert property (@(posedge clk) disable iff (pwr_rst)
      armed && usr_rst && en_q |=> en_q && $stable(gen_q));
  end
endmodule

// File: rtl/clkrt_rdsel.sv
module clkrt_rdsel
  import clkrt_pkg::*;
#(
  parameter int NUM_CH = 38
) (
  input  logic                         clk,
  input  logic                         pwr_rst,
  input  logic                         wr_en,
  input  logic [ID_W-1:0]              wr_id,
  input  logic [NUM_CH-1:0][GEN_W-1:0] ent_gen,
  input  logic [NUM_CH-1:0]            ent_en,
  input  logic [NUM_CH-1:0]            ent_lock,
  output ctl_word_t                    rd_word
);
  logic [ID_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (pwr_rst)    ptr_q <= '0;
    else if (wr_en) ptr_q <= wr_id;
  end

  always_comb begin
    rd_word    = '0;
    rd_word.id = ptr_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ptr_q == ID_W'(k)) begin
        rd_word.gen  = ent_gen[k];
        rd_word.en   = ent_en[k];
        rd_word.lock = ent_lock[k];
      end
    end
  end

  assert_reserved_reads_zero_R8: assert property (@(posedge clk) disable iff (pwr_rst)
    wr_en && wr_id >= ID_W'(NUM_CH) |=> rd_word[WORD_W-1:ID_W] == '0);
endmodule

// File: rtl/clk_route_bank.sv
module clk_route_bank
  import clkrt_pkg::*;
#(
  parameter int               NUM_CH  = 38,
  parameter int               WDT_ID  = 3,
  parameter int               RTC_ID  = 4,
  parameter logic [GEN_W-1:0] WDT_GEN = 4'd2
) (
  input  logic                    clk,
  input  logic                    power_rst,
  input  logic                    user_rst,
  input  logic                    nv_wdt_en,
  input  logic                    nv_wdt_lock,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_word,
  output logic [WORD_W-1:0]       rd_word,
  output logic [NUM_CH*GEN_W-1:0] ch_gen_o,
  output logic [NUM_CH-1:0]       ch_en_o
);
  ctl_word_t w;
  assign w = ctl_word_t'(wr_word);

  logic unused_rsv;
  assign unused_rsv = ^{w.rsv_hi, w.rsv_lo};

  logic [NUM_CH-1:0][GEN_W-1:0] ent_gen;
  logic [NUM_CH-1:0]            ent_en;
  logic [NUM_CH-1:0]            ent_lock;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam kind_e K = (k == WDT_ID) ? KIND_WDT :
                          (k == RTC_ID) ? KIND_RTC : KIND_PLAIN;
    logic hit;
    assign hit = wr_en && (w.id == ID_W'(k));

    clkrt_entry #(.KIND(K), .PWR_GEN(WDT_GEN)) u_ent (
      .clk       (clk),
      .pwr_rst   (power_rst),
      .usr_rst   (user_rst),
      .nv_en     (nv_wdt_en),
      .nv_lock   (nv_wdt_lock),
      .wr_hit    (hit),
      .wr_gen    (w.gen),
      .wr_en_bit (w.en),
      .wr_lock   (w.lock),
      .gen_o     (ent_gen[k]),
      .en_o      (ent_en[k]),
      .lock_o    (ent_lock[k])
    );
    assign ch_gen_o[k*GEN_W +: GEN_W] = ent_gen[k];
  end

  assign ch_en_o = ent_en;

  ctl_word_t rd_s;
  clkrt_rdsel #(.NUM_CH(NUM_CH)) u_rd (
    .clk      (clk),
    .pwr_rst  (power_rst),
    .wr_en    (wr_en),
    .wr_id    (w.id),
    .ent_gen  (ent_gen),
    .ent_en   (ent_en),
    .ent_lock (ent_lock),
    .rd_word  (rd_s)
  );
  assign rd_word = WORD_W'(rd_s);

  assert_pwr_defaults_R2: assert property (@(posedge clk)
    $fell(power_rst) |-> ch_en_o[WDT_ID] == $past(nv_wdt_en) &&
      (ch_en_o & ~(NUM_CH'(1) << WDT_ID)) == '0 &&
      ch_gen_o[WDT_ID*GEN_W +: GEN_W] == WDT_GEN);
endmodule

// File: tb/tb_clk_route_bank.sv
module tb_clk_route_bank;
  localparam int NCH = 38;

  logic          clk = 1'b0;
  logic          power_rst = 1'b1;
  logic          user_rst = 1'b0;
  logic          nv_wdt_en = 1'b1;
  logic          nv_wdt_lock = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_word = '0;
  logic [15:0]   rd_word;
  logic [NCH*4-1:0] ch_gen_o;
  logic [NCH-1:0]   ch_en_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_route_bank dut (
    .clk(clk), .power_rst(power_rst), .user_rst(user_rst),
    .nv_wdt_en(nv_wdt_en), .nv_wdt_lock(nv_wdt_lock),
    .wr_en(wr_en), .wr_word(wr_word), .rd_word(rd_word),
    .ch_gen_o(ch_gen_o), .ch_en_o(ch_en_o)
  );

  // {write word, expected read word}
  localparam logic [31:0] VEC [10] = '{
    {16'h4305, 16'h4305},   // R1 plain write
    {16'h0F25, 16'h0F25},   // R1 top valid channel
    {16'hC726, 16'h0026},   // R8 first reserved
    {16'h413F, 16'h003F},   // R8 last reserved
    {16'hC910, 16'hC910},   // R1 write with lock
    {16'h0210, 16'hC910},   // R7 locked entry ignores write
    {16'h4400, 16'h4400},   // R9 channel 0
    {16'h0A02, 16'h0A02},   // R9 disabled entry
    {16'h4604, 16'h4604},   // R1 timekeeping enabled
    {16'h4507, 16'h4507}    // R1 ordinary enabled
  };

  task automatic chk(input string req, input logic [NCH*4-1:0] got,
                     input logic [NCH*4-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] word);
    @(negedge clk);
    wr_en = 1'b1;
    wr_word = word;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_user();
    @(negedge clk);
    user_rst = 1'b1;
    @(negedge clk);
    user_rst = 1'b0;
  endtask

  function automatic logic [3:0] gen_of(int k);
    return ch_gen_o[k*4 +: 4];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    power_rst = 1'b0;
    chk("R2 enables after power reset", ch_en_o, 38'h8);
    chk("R2 watchdog generator", gen_of(3), 4'd2);
    chk("R2 read pointer at channel 0", rd_word, 16'h0000);

    foreach (VEC[i]) begin
      do_write(VEC[i][31:16]);
      chk($sformatf("R1/R7/R8/R9 vector %0d", i), rd_word, VEC[i][15:0]);
    end
    chk("R11 generator slice channel 5", gen_of(5), 4'd3);
    chk("R11 enable channel 16", ch_en_o[16], 1'b1);

    do_write(16'h0503);
    chk("R1 watchdog rewrite", rd_word, 16'h0503);

    pulse_user();
    chk("R3 unlocked ch5 enable cleared", ch_en_o[5], 1'b0);
    chk("R3 unlocked ch5 generator cleared", gen_of(5), 4'd0);
    chk("R3 unlocked ch7 cleared", {ch_en_o[7], gen_of(7)}, 5'h0);
    chk("R3 locked ch16 kept", {ch_en_o[16], gen_of(16)}, 5'h19);
    chk("R4 enabled timekeeping kept", {ch_en_o[4], gen_of(4)}, 5'h16);
    chk("R5 watchdog reload", {ch_en_o[3], gen_of(3)}, 5'h12);

    do_write(16'h0110);
    chk("R6 R7 lock survives user reset", rd_word, 16'hC910);

    do_write(16'h0604);
    chk("R1 timekeeping disabled", rd_word, 16'h0604);
    pulse_user();
    chk("R4 unlocked disabled timekeeping cleared", gen_of(4), 4'd0);
    do_write(16'h8704);
    pulse_user();
    chk("R4 locked disabled timekeeping kept", gen_of(4), 4'd7);
    chk("R6 timekeeping lock kept", rd_word, 16'h8704);

    @(negedge clk);
    user_rst = 1'b1; wr_en = 1'b1; wr_word = 16'h4505;
    @(negedge clk);
    user_rst = 1'b0; wr_en = 1'b0;
    chk("R10 user reset beats write", {ch_en_o[5], gen_of(5)}, 5'h0);
    chk("R10 pointer follows write", rd_word, 16'h0005);

    @(negedge clk);
    nv_wdt_en = 1'b0; nv_wdt_lock = 1'b1;
    power_rst = 1'b1; user_rst = 1'b1; wr_en = 1'b1; wr_word = 16'h4505;
    @(negedge clk);
    power_rst = 1'b0; user_rst = 1'b0; wr_en = 1'b0;
    chk("R10 power reset wins", ch_en_o, 38'h0);
    chk("R2 watchdog generator from reset", gen_of(3), 4'd2);
    chk("R2 locked ch16 cleared", gen_of(16), 4'd0);

    do_write(16'h4503);
    chk("R7 locked watchdog ignores write", rd_word, 16'h8203);
    pulse_user();
    chk("R5 locked watchdog unchanged", rd_word, 16'h8203);
    do_write(16'h0110);
    chk("R7 power reset released lock", rd_word, 16'h0110);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule